// File: doc/BRIEF.md
# Debug Trigger and Capture Unit

The unit watches a CPU bus access stream and compares each valid access against two programmable comparators, A and B. Each comparator holds a full address. For the data modes, the low byte of B is the data value to compare. A 4-bit mode field picks one of nine trigger conditions: single address, either address, A then B, address with matching data, address with differing data, the two event-store modes, and inside or outside an address window. When the condition is met, the unit raises a breakpoint request. A force request fires on the access itself. A tag request marks an opcode fetch and fires only when the core reports that the tagged opcode executes.

While armed, the unit records captures into an 8-entry, 16-bit FIFO. In the event modes it records the data byte of each qualifying B match. In all other modes it records the address of every change-of-flow access. A host reads the FIFO head directly, pops entries one at a time, and watches the occupancy count and the overflow flag. Writes through a small register port load the two comparator values and a control word.

The control sequencer is a three-state machine. ST_IDLE is the disarmed state. ST_ARMED is armed and waiting for the mode's condition; in the two sequence modes it waits for A. ST_GOT_A means A has been seen and the unit waits for B. The transitions are:
- arm: a control write with the arm bit set moves any state to ST_ARMED.
- disarm: a control write with the arm bit clear moves any state to ST_IDLE.
- see_a: an A hit in ST_ARMED, in the sequence modes, moves to ST_GOT_A.
- fire_stop: a trigger without continuous mode moves to ST_IDLE.
- fire_rearm: a trigger in continuous mode moves to ST_ARMED. In the A-then-event mode it stays in ST_GOT_A instead.

Top module: `dbg_trigger_unit`

## Requirements
- R1: After reset the unit is disarmed (`armed`=0). The FIFO is empty (`cap_count`=0), `cap_ovf`=0, and both breakpoint outputs are 0.
- R2: Comparators hit only on cycles with `bus_valid`=1. Each comparator has a 2-bit R/W qualifier (`bus_rw`=1 means a read): 1 is read-only, 2 is write-only, and 0 or 3 is don't-care. In tag mode only accesses with `bus_fetch`=1 can hit.
- R3: Mode 0 fires on an A address hit. Mode 1 fires on an A hit or a B hit.
- R4: Mode 2 arms on an A hit and fires on the first B hit in a later cycle. A B hit before A does not fire. Disarming forgets a seen A.
- R5: Mode 3 fires on an A address hit whose data equals B bits [7:0]. Mode 4 fires on an A address hit whose data differs from B bits [7:0].
- R6: Mode 7 fires when A ≤ address ≤ B. Mode 8 fires when address < A or address > B. Both use the A qualifier.
- R7: Mode 5 fires and stores the zero-extended data byte on every B hit. Mode 6 does the same, but only for B hits after an A hit.
- R8: A trigger disarms the unit unless the continuous bit is set.
- R9: In force mode (tag bit 0), `brk_force` is a one-cycle pulse in the cycle after the triggering access.
- R10: In tag mode (tag bit 1), a trigger leaves `brk_force` low and records a pending tag. `brk_tag` pulses in the cycle after the first `exec_go`. An `exec_flush` before that cancels the tag.
- R11: In modes other than 5 and 6, every valid access with `bus_cof`=1 while armed pushes its address. Nothing is captured while disarmed.
- R12: A push to a full FIFO (8 entries) is dropped and sets `cap_ovf`. A control write with the arm bit set clears `cap_ovf`. `cap_pop` removes the oldest entry, and `cap_count` gives the occupancy.
- R13: Mode codes 9 to 15 never fire and do not disarm the unit.

Register port: `cfg_sel` 0 writes comparator A, 1 writes comparator B, and 2 writes the control word. The control word fields are: mode [3:0], arm [4], continuous [5], tag [6], A qualifier [8:7] and B qualifier [10:9].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_valid | input | 1 | Access strobe |
| bus_addr | input | 16 | Access address |
| bus_data | input | 8 | Access data |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_cof | input | 1 | Access is a change-of-flow target |
| bus_fetch | input | 1 | Access is an opcode fetch |
| exec_go | input | 1 | Tagged opcode reaches execution |
| exec_flush | input | 1 | Pipeline flush, drops a pending tag |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 16 | Register write data |
| cap_pop | input | 1 | Pop oldest capture |
| cap_data | output | 16 | Oldest capture (valid when count > 0) |
| cap_count | output | 4 | FIFO occupancy |
| cap_ovf | output | 1 | Capture dropped on a full FIFO |
| armed | output | 1 | Unit armed |
| brk_force | output | 1 | Force breakpoint request |
| brk_tag | output | 1 | Tag breakpoint request |

## Verification
Every result is registered exactly once. `brk_force`, `armed`, `cap_count` and `cap_ovf` change at the first clock edge after the access or control write. `brk_tag` changes at the first edge after `exec_go`, so the tag path adds one edge beyond the trigger. The bench drives each stimulus on a falling edge, holds it across one rising edge and samples at the next falling edge. Each check therefore lands in the one cycle where the result is due, and the pulse outputs are seen before they drop. Expected capture words are queued as each access is driven, and the drain step pops the FIFO head and compares it against the queue front in order.

// File: rtl/dtu_pkg.sv
package dtu_pkg;

    localparam logic [3:0] M_A_ONLY     = 4'd0;
    localparam logic [3:0] M_A_OR_B     = 4'd1;
    localparam logic [3:0] M_A_THEN_B   = 4'd2;
    localparam logic [3:0] M_A_DATA     = 4'd3;
    localparam logic [3:0] M_A_NDATA    = 4'd4;
    localparam logic [3:0] M_EVT_B      = 4'd5;
    localparam logic [3:0] M_A_THEN_EVT = 4'd6;
    localparam logic [3:0] M_IN_RANGE   = 4'd7;
    localparam logic [3:0] M_OUT_RANGE  = 4'd8;

    localparam int CTRL_W = 11;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_GOT_A = 2'd2
    } trig_state_e;

    typedef struct packed {
        logic [1:0] rwq_b;
        logic [1:0] rwq_a;
        logic       tag;
        logic       cont;
        logic       arm;
        logic [3:0] mode;
    } ctrl_t;

    function automatic logic rw_ok(input logic [1:0] q, input logic rw);
        unique case (q)
            2'd1:    rw_ok = rw;
            2'd2:    rw_ok = !rw;
            default: rw_ok = 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/dtu_cmp.sv
module dtu_cmp
    import dtu_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    input  logic              rw,
    input  logic              fetch,
    input  logic              tag_sel,
    input  logic [ADDR_W-1:0] ref_a,
    input  logic [ADDR_W-1:0] ref_b,
    input  logic [1:0]        rwq_a,
    input  logic [1:0]        rwq_b,
    output logic              hit_a,
    output logic              hit_b,
    output logic              data_eq,
    output logic              in_rng,
    output logic              out_rng
);
    logic [1:0]              qual;
    logic [1:0]              eq;
    logic [1:0][ADDR_W-1:0]  refs;
    logic [1:0][1:0]         quals;
    logic                    acc_ok;

    assign refs   = {ref_b, ref_a};
    assign quals  = {rwq_b, rwq_a};
    assign acc_ok = valid && (!tag_sel || fetch);

    for (genvar i = 0; i < 2; i++) begin : g_chan
        assign qual[i] = acc_ok && rw_ok(quals[i], rw);
        assign eq[i]   = qual[i] && (addr == refs[i]);
    end

    assign hit_a   = eq[0];
    assign hit_b   = eq[1];
    assign data_eq = (data == ref_b[DATA_W-1:0]);
    assign in_rng  = qual[0] && (addr >= ref_a) && (addr <= ref_b);
    assign out_rng = qual[0] && ((addr < ref_a) || (addr > ref_b));
endmodule

// File: rtl/dtu_capfifo.sv
module dtu_capfifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    input  logic          clr_ovf,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          ovf
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          do_pop, do_push;

    assign do_pop  = pop && (count != '0);
    assign do_push = push && ((count != CW'(DEPTH)) || do_pop);
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovf    <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
            if (push && !do_push) ovf <= 1'b1;
            else if (clr_ovf)     ovf <= 1'b0;
        end
    end
endmodule

// File: rtl/dbg_trigger_unit.sv
module dbg_trigger_unit
    import dtu_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 8,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              bus_rw,
    input  logic              bus_cof,
    input  logic              bus_fetch,
    input  logic              exec_go,
    input  logic              exec_flush,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              cap_pop,
    output logic [ADDR_W-1:0] cap_data,
    output logic [CNT_W-1:0]  cap_count,
    output logic              cap_ovf,
    output logic              armed,
    output logic              brk_force,
    output logic              brk_tag
);
    trig_state_e       state_q, state_d;
    ctrl_t             ctrl_q;
    logic [ADDR_W-1:0] ref_a_q, ref_b_q;
    logic              hit_a, hit_b, data_eq, in_rng, out_rng;
    logic              fire, evt_mode, ctrl_wr, push;
    logic              tag_pend;
    logic [ADDR_W-1:0] push_data;

    assign ctrl_wr  = cfg_we && (cfg_sel == 2'd2);
    assign evt_mode = (ctrl_q.mode == M_EVT_B) || (ctrl_q.mode == M_A_THEN_EVT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_a_q <= '0;
            ref_b_q <= '0;
            ctrl_q  <= '0;
        end else if (cfg_we) begin
            unique case (cfg_sel)
                2'd0:    ref_a_q <= cfg_wdata;
                2'd1:    ref_b_q <= cfg_wdata;
                2'd2:    ctrl_q  <= ctrl_t'(cfg_wdata[CTRL_W-1:0]);
                default: ;
            endcase
        end
    end

    dtu_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmp (
        .valid   (bus_valid),
        .addr    (bus_addr),
        .data    (bus_data),
        .rw      (bus_rw),
        .fetch   (bus_fetch),
        .tag_sel (ctrl_q.tag),
        .ref_a   (ref_a_q),
        .ref_b   (ref_b_q),
        .rwq_a   (ctrl_q.rwq_a),
        .rwq_b   (ctrl_q.rwq_b),
        .hit_a   (hit_a),
        .hit_b   (hit_b),
        .data_eq (data_eq),
        .in_rng  (in_rng),
        .out_rng (out_rng)
    );

    // Next-state and trigger decision
    always_comb begin
        state_d = state_q;
        fire    = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ARMED: begin
                unique case (ctrl_q.mode)
                    M_A_ONLY:     fire = hit_a;
                    M_A_OR_B:     fire = hit_a || hit_b;
                    M_A_THEN_B,
                    M_A_THEN_EVT: if (hit_a) state_d = ST_GOT_A;
                    M_A_DATA:     fire = hit_a && data_eq;
                    M_A_NDATA:    fire = hit_a && !data_eq;
                    M_EVT_B:      fire = hit_b;
                    M_IN_RANGE:   fire = in_rng;
                    M_OUT_RANGE:  fire = out_rng;
                    default:      fire = 1'b0;
                endcase
            end
            ST_GOT_A: begin
                if ((ctrl_q.mode == M_A_THEN_B) || (ctrl_q.mode == M_A_THEN_EVT))
                    fire = hit_b;
            end
            default: state_d = ST_IDLE;
        endcase
        if (fire) begin
            if (!ctrl_q.cont)                     state_d = ST_IDLE;
            else if (ctrl_q.mode == M_A_THEN_EVT) state_d = ST_GOT_A;
            else                                  state_d = ST_ARMED;
        end
        if (ctrl_wr) state_d = cfg_wdata[4] ? ST_ARMED : ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output process: breakpoint requests
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            brk_force <= 1'b0;
            brk_tag   <= 1'b0;
            tag_pend  <= 1'b0;
        end else begin
            brk_force <= fire && !ctrl_q.tag;
            brk_tag   <= tag_pend && exec_go;
            if (ctrl_wr || exec_go || exec_flush) tag_pend <= 1'b0;
            else if (fire && ctrl_q.tag)          tag_pend <= 1'b1;
        end
    end

    assign armed     = (state_q != ST_IDLE);
    assign push      = evt_mode ? fire : (armed && bus_valid && bus_cof);
    assign push_data = evt_mode ? ADDR_W'(bus_data) : bus_addr;

    dtu_capfifo #(.W(ADDR_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (push_data),
        .pop       (cap_pop),
        .clr_ovf   (ctrl_wr && cfg_wdata[4]),
        .head      (cap_data),
        .count     (cap_count),
        .ovf       (cap_ovf)
    );
endmodule

// File: rtl/dtu_checker.sv
module dtu_checker #(
    parameter int FIFO_DEPTH = 8,
    parameter int CNT_W      = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_valid,
    input logic             exec_go,
    input logic             armed,
    input logic             brk_force,
    input logic             brk_tag,
    input logic [CNT_W-1:0] cap_count,
    input logic             cap_ovf
);
    a_r9_brk_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        brk_force |-> $past(armed));

    a_r2_brk_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        brk_force |-> $past(bus_valid));

    a_r10_tag_after_exec: assert property (@(posedge clk) disable iff (!rst_n)
        brk_tag |-> $past(exec_go));

    a_r12_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cap_count <= CNT_W'(FIFO_DEPTH));

    a_r12_ovf_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cap_ovf) |-> (cap_count == CNT_W'(FIFO_DEPTH)));

    a_r12_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_count == $past(cap_count)) ||
        (cap_count == $past(cap_count) + CNT_W'(1)) ||
        (cap_count + CNT_W'(1) == $past(cap_count)));
endmodule

bind dbg_trigger_unit dtu_checker #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .exec_go   (exec_go),
    .armed     (armed),
    .brk_force (brk_force),
    .brk_tag   (brk_tag),
    .cap_count (cap_count),
    .cap_ovf   (cap_ovf)
);

// File: tb/dbg_trigger_unit_bench.sv
module dbg_trigger_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 0, bus_rw = 0, bus_cof = 0, bus_fetch = 0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_data = '0;
    logic        exec_go = 0, exec_flush = 0;
    logic        cfg_we = 0;
    logic [1:0]  cfg_sel = '0;
    logic [15:0] cfg_wdata = '0;
    logic        cap_pop = 0;
    logic [15:0] cap_data;
    logic [3:0]  cap_count;
    logic        cap_ovf, armed, brk_force, brk_tag;

    int          n_chk = 0;
    int          n_err = 0;
    logic [15:0] exp_q[$];
    logic        got;

    always #5 clk = ~clk;

    dbg_trigger_unit u_dbg_trigger_unit (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] val);
        cfg_we = 1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic ctrl(input int mode, input bit arm, input bit cont, input bit tag,
                        input int rwa, input int rwb);
        wr(2'd2, 16'((rwb << 9) | (rwa << 7) | (int'(tag) << 6) | (int'(cont) << 5)
                    | (int'(arm) << 4) | mode));
    endtask

    task automatic acc(input logic [15:0] a, input logic [7:0] d, input bit rw,
                       input bit cof, input bit fetch, input bit vld = 1'b1);
        bus_valid = vld; bus_addr = a; bus_data = d; bus_rw = rw;
        bus_cof = cof; bus_fetch = fetch;
        @(negedge clk);
        got = brk_force;
        bus_valid = 0; bus_cof = 0; bus_fetch = 0;
    endtask

    task automatic drain(input string req);
        while (cap_count != 0) begin
            if (exp_q.size() == 0) chk({req, " extra capture"}, cap_data, 16'hxxxx);
            else chk(req, cap_data, exp_q.pop_front());
            cap_pop = 1;
            @(negedge clk);
            cap_pop = 0;
        end
        chk({req, " all expected seen"}, exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 armed", armed, 0);
        chk("R1 count", cap_count, 0);
        chk("R1 ovf", cap_ovf, 0);
        chk("R1 brk", {brk_force, brk_tag}, 0);

        wr(2'd0, 16'h1000);
        wr(2'd1, 16'h2000);

        // R3 mode 0, R8 auto disarm, R9 pulse
        ctrl(0, 1, 0, 0, 0, 0);
        chk("R8 armed after write", armed, 1);
        acc(16'h1004, 0, 1, 0, 0);  chk("R3 A-only miss", got, 0);
        acc(16'h1000, 0, 1, 0, 0);  chk("R3 A-only hit", got, 1);
        chk("R8 disarm after fire", armed, 0);
        @(negedge clk);             chk("R9 one-cycle pulse", brk_force, 0);

        // R3 mode 1 with R2 qualifier, R8 continuous
        ctrl(1, 1, 1, 0, 1, 0);
        acc(16'h1000, 0, 0, 0, 0);  chk("R2 write blocked by read-only A", got, 0);
        acc(16'h2000, 0, 0, 0, 0);  chk("R3 A-or-B B hit", got, 1);
        chk("R8 continuous stays armed", armed, 1);
        acc(16'h1000, 0, 1, 0, 0);  chk("R3 A-or-B A read hit", got, 1);
        acc(16'h1000, 0, 1, 0, 0, 1'b0); chk("R2 no hit without valid", got, 0);

        // R4 sequence
        ctrl(2, 1, 0, 0, 0, 0);
        acc(16'h2000, 0, 1, 0, 0);  chk("R4 B before A", got, 0);
        acc(16'h1000, 0, 1, 0, 0);  chk("R4 A arms", got, 0);
        acc(16'h2000, 0, 1, 0, 0);  chk("R4 B after A", got, 1);
        chk("R4 disarm after fire", armed, 0);
        ctrl(2, 1, 0, 0, 0, 0);
        acc(16'h1000, 0, 1, 0, 0);
        ctrl(2, 0, 0, 0, 0, 0);
        ctrl(2, 1, 0, 0, 0, 0);
        acc(16'h2000, 0, 1, 0, 0);  chk("R4 disarm forgets A", got, 0);

        // R5 data modes
        wr(2'd1, 16'h0055);
        ctrl(3, 1, 0, 0, 0, 0);
        acc(16'h1000, 8'h54, 0, 0, 0); chk("R5 data mismatch", got, 0);
        acc(16'h1000, 8'h55, 0, 0, 0); chk("R5 data match", got, 1);
        ctrl(4, 1, 0, 0, 0, 0);
        acc(16'h1000, 8'h55, 0, 0, 0); chk("R5 not-data equal", got, 0);
        acc(16'h1000, 8'h54, 0, 0, 0); chk("R5 not-data differ", got, 1);

        // R6 ranges
        wr(2'd0, 16'h2000);
        wr(2'd1, 16'h2010);
        ctrl(7, 1, 1, 0, 0, 0);
        acc(16'h1FFF, 0, 1, 0, 0); chk("R6 inside below", got, 0);
        acc(16'h2000, 0, 1, 0, 0); chk("R6 inside low edge", got, 1);
        acc(16'h2010, 0, 1, 0, 0); chk("R6 inside high edge", got, 1);
        acc(16'h2011, 0, 1, 0, 0); chk("R6 inside above", got, 0);
        ctrl(8, 1, 1, 0, 0, 0);
        acc(16'h1FFF, 0, 1, 0, 0); chk("R6 outside below", got, 1);
        acc(16'h2000, 0, 1, 0, 0); chk("R6 outside edge", got, 0);
        acc(16'h2011, 0, 1, 0, 0); chk("R6 outside above", got, 1);

        // R13 reserved mode
        ctrl(9, 1, 0, 0, 0, 0);
        acc(16'h2000, 0, 1, 0, 0); chk("R13 reserved no fire", got, 0);
        chk("R13 stays armed", armed, 1);
        drain("R13 nothing captured");

        // R11 change-of-flow capture
        wr(2'd0, 16'h1000);
        wr(2'd1, 16'h2000);
        ctrl(0, 1, 1, 0, 0, 0);
        acc(16'h3000, 0, 1, 1, 0); exp_q.push_back(16'h3000);
        acc(16'h3100, 0, 1, 1, 0); exp_q.push_back(16'h3100);
        acc(16'h3200, 0, 1, 0, 0);
        chk("R11 count", cap_count, 2);
        drain("R11 cof capture");
        ctrl(0, 0, 0, 0, 0, 0);
        acc(16'h3300, 0, 1, 1, 0);
        chk("R11 disarmed no capture", cap_count, 0);

        // R7 event modes
        ctrl(5, 1, 1, 0, 0, 0);
        acc(16'h2000, 8'h11, 1, 1, 0); chk("R7 event B fires", got, 1);
        exp_q.push_back(16'h0011);
        acc(16'h1000, 8'h22, 1, 1, 0);
        drain("R7 event-only B");
        ctrl(6, 1, 1, 0, 0, 0);
        acc(16'h2000, 8'h33, 1, 0, 0); chk("R7 B before A", got, 0);
        acc(16'h1000, 8'h34, 1, 0, 0);
        acc(16'h2000, 8'h44, 1, 0, 0); chk("R7 B after A", got, 1);
        exp_q.push_back(16'h0044);
        acc(16'h2000, 8'h45, 1, 0, 0); exp_q.push_back(16'h0045);
        drain("R7 A then event B");

        // R12 overflow
        ctrl(0, 1, 1, 0, 0, 0);
        for (int i = 0; i < 9; i++) begin
            acc(16'h4000 + 16'(i), 0, 1, 1, 0);
            if (i < 8) exp_q.push_back(16'h4000 + 16'(i));
        end
        chk("R12 full count", cap_count, 8);
        chk("R12 ovf set", cap_ovf, 1);
        ctrl(0, 0, 0, 0, 0, 0);
        drain("R12 oldest first");
        chk("R12 ovf held", cap_ovf, 1);
        ctrl(0, 1, 0, 0, 0, 0);
        chk("R12 ovf cleared by arm", cap_ovf, 0);

        // R10 tag breakpoints
        ctrl(0, 1, 0, 1, 0, 0);
        acc(16'h1000, 0, 1, 0, 0); chk("R10 non-fetch ignored", armed, 1);
        acc(16'h1000, 0, 1, 0, 1); chk("R10 no force in tag mode", got, 0);
        exec_go = 1; @(negedge clk); exec_go = 0;
        chk("R10 tag on execute", brk_tag, 1);
        exec_go = 1; @(negedge clk); exec_go = 0;
        chk("R10 tag consumed", brk_tag, 0);
        ctrl(0, 1, 0, 1, 0, 0);
        acc(16'h1000, 0, 1, 0, 1);
        exec_flush = 1; @(negedge clk); exec_flush = 0;
        exec_go = 1; @(negedge clk); exec_go = 0;
        chk("R10 flush cancels tag", brk_tag, 0);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule